// File: doc/BRIEF.md
# Zero-Cross Gated Gain Updater

This block holds the active input-gain and volume codes for the left and right channels of one stereo audio path. A control interface hands it a freshly latched set of codes together with the zero-cross mode bits on a one-cycle load strobe. When zero-cross gating is off, the new codes are applied at once. When it is on, each channel keeps the new codes as a pending change. The change is applied only when that channel's comparator reports a zero crossing at the watched stage, so that a step in gain does not click.

The watched stage is either the input-gain stage or the volume stage. It is chosen by a manual select bit, or, in automatic mode, by whether the volume code actually changes. A fallback timer applies any change still pending once a selectable number of millisecond ticks has passed. A later load replaces a pending change and restarts the timer. The applied codes are sanitised, so that the downstream ladder decoders never see an illegal value.

Top module: `zc_gain_updater`

## Requirements
- R1: After reset both channels apply input gain code 0 and volume code 80 (mute), and no change is pending.
- R2: A load with gate_en_i = 0 applies all four loaded codes on the clock edge that samples the load, and it clears any pending change.
- R3: A load with gate_en_i = 1 leaves the applied codes unchanged. It makes the loaded codes pending on each channel, and they are applied only on that channel's comparator pulse from the watched stage. Pulses from the other stage are ignored.
- R4: In manual mode (auto_i = 0), stage_sel_i = 0 watches the input-gain stage comparator and stage_sel_i = 1 watches the volume stage comparator.
- R5: In automatic mode (auto_i = 1), stage_sel_i is ignored. A channel watches the volume stage when its loaded volume code differs from its applied one, and the input-gain stage otherwise.
- R6: Each channel has its own pending change and is committed only by its own comparator pulses.
- R7: The timer field tmo_sel_i, read as an unsigned value {bit1,bit0}, sets the fallback time: 0 is 10, 1 is 20, 2 is 40 and 3 is 80 ms ticks. Counting starts after the load, and a change still pending is applied on the tick that completes the count.
- R8: A gated load that arrives while a change is pending replaces the pending codes and restarts the fallback count.
- R9: Volume codes 0 to 79 mean n dB attenuation, 80 means mute, and 118 to 127 mean a boost of (128 - code) dB. Any other loaded code is applied as 80.
- R10: Input gain codes 0 to 18 mean +n dB. A loaded code above 18 is applied as 18.
- R11: The mode bits travel with the data. One load can switch a channel with a pending change to immediate application, and the pending change is then discarded, so later pulses and ticks do nothing.
- R12: Comparator pulses and ticks while nothing is pending leave the applied codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-cycle strobe: new codes and mode bits are valid |
| gate_en_i | input | 1 | 1 = wait for zero crossing, 0 = apply at once |
| stage_sel_i | input | 1 | Manual watched stage: 0 input gain, 1 volume |
| auto_i | input | 1 | 1 = automatic stage choice |
| tmo_sel_i | input | 2 | Fallback timer select |
| gain_l_i | input | 5 | Loaded left input gain code |
| gain_r_i | input | 5 | Loaded right input gain code |
| vol_l_i | input | 8 | Loaded left volume code |
| vol_r_i | input | 8 | Loaded right volume code |
| zc_gain_l_i | input | 1 | Left zero-cross pulse at the input-gain stage |
| zc_gain_r_i | input | 1 | Right zero-cross pulse at the input-gain stage |
| zc_vol_l_i | input | 1 | Left zero-cross pulse at the volume stage |
| zc_vol_r_i | input | 1 | Right zero-cross pulse at the volume stage |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| gain_l_o | output | 5 | Applied left input gain code |
| gain_r_o | output | 5 | Applied right input gain code |
| vol_l_o | output | 8 | Applied left volume code |
| vol_r_o | output | 8 | Applied right volume code |

## Verification
The assertions check on every cycle that the applied codes move only on a load or a commit event, and that a commit never happens without a pending change. They also check that a gated load always leaves a change pending, that the fallback counter stays below its limit, and that the applied codes always lie in their legal sets. Which comparator stage is watched, the automatic choice, the exact tick on which the fallback fires for each timer setting, and replacement of a pending change can only be shown by the bench's scenarios. In each of those scenarios the bench compares the applied codes against values it has worked out itself.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int GAIN_W        = 5;
  localparam int VOL_W         = 8;
  localparam int GAIN_MAX      = 18;
  localparam int VOL_MUTE      = 80;
  localparam int VOL_BOOST_MAX = 10;
  localparam int VOL_BOOST_LO  = 128 - VOL_BOOST_MAX;

  typedef logic [GAIN_W-1:0] gain_t;
  typedef logic [VOL_W-1:0]  vol_t;

  typedef struct packed {
    logic       gate_en;
    logic       stage_sel;
    logic       auto_sel;
    logic [1:0] tmo_sel;
  } zc_mode_t;

  // Saturate an input gain code to its top step.
  function automatic gain_t gain_sat(input gain_t g);
    return (g > gain_t'(GAIN_MAX)) ? gain_t'(GAIN_MAX) : g;
  endfunction

  // A volume code is legal when it is an attenuation, mute or a boost step.
  function automatic logic vol_is_legal(input vol_t v);
    return (v <= vol_t'(VOL_MUTE)) ||
           ((v >= vol_t'(VOL_BOOST_LO)) && (v <= vol_t'(127)));
  endfunction

  function automatic vol_t vol_clean(input vol_t v);
    return vol_is_legal(v) ? v : vol_t'(VOL_MUTE);
  endfunction
endpackage

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int BASE_MS = 10,
  parameter int CNT_W   = $clog2(BASE_MS * 8 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [1:0]       tmo_sel_i,
  input  logic             any_pend_i,
  input  logic             ms_tick_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] limit_o
);
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             last_tick;

  // Fallback time doubles with each step of the select field.
  assign limit     = CNT_W'(BASE_MS) << sel_q;
  assign last_tick = (cnt_q == limit - CNT_W'(1));
  assign expire_o  = any_pend_i && ms_tick_i && last_tick && !load_i;
  assign cnt_o     = cnt_q;
  assign limit_o   = limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sel_q <= tmo_sel_i;
      cnt_q <= '0;
    end else if (any_pend_i && ms_tick_i) begin
      cnt_q <= last_tick ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/zc_chan.sv
module zc_chan
  import zc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  zc_mode_t mode_i,
  input  gain_t    gain_i,
  input  vol_t     vol_i,
  input  logic     zc_gain_i,
  input  logic     zc_vol_i,
  input  logic     expire_i,
  output gain_t    gain_o,
  output vol_t     vol_o,
  output logic     pend_o,
  output logic     commit_o
);
  gain_t gain_q, gain_p, gain_n;
  vol_t  vol_q, vol_p, vol_n;
  logic  pend_q, watch_vol_q, watch_vol_n, zc_hit;

  assign gain_n      = gain_sat(gain_i);
  assign vol_n       = vol_clean(vol_i);
  assign watch_vol_n = mode_i.auto_sel ? (vol_n != vol_q) : mode_i.stage_sel;
  assign zc_hit      = watch_vol_q ? zc_vol_i : zc_gain_i;
  assign commit_o    = pend_q && !load_i && (zc_hit || expire_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q      <= '0;
      vol_q       <= vol_t'(VOL_MUTE);
      gain_p      <= '0;
      vol_p       <= vol_t'(VOL_MUTE);
      pend_q      <= 1'b0;
      watch_vol_q <= 1'b0;
    end else if (load_i) begin
      if (mode_i.gate_en) begin
        gain_p      <= gain_n;
        vol_p       <= vol_n;
        pend_q      <= 1'b1;
        watch_vol_q <= watch_vol_n;
      end else begin
        gain_q <= gain_n;
        vol_q  <= vol_n;
        pend_q <= 1'b0;
      end
    end else if (commit_o) begin
      gain_q <= gain_p;
      vol_q  <= vol_p;
      pend_q <= 1'b0;
    end
  end

  assign gain_o = gain_q;
  assign vol_o  = vol_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/zc_gain_updater.sv
module zc_gain_updater
  import zc_pkg::*;
#(
  parameter int BASE_MS = 10,
  parameter int N_CH    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       gate_en_i,
  input  logic       stage_sel_i,
  input  logic       auto_i,
  input  logic [1:0] tmo_sel_i,
  input  logic [4:0] gain_l_i,
  input  logic [4:0] gain_r_i,
  input  logic [7:0] vol_l_i,
  input  logic [7:0] vol_r_i,
  input  logic       zc_gain_l_i,
  input  logic       zc_gain_r_i,
  input  logic       zc_vol_l_i,
  input  logic       zc_vol_r_i,
  input  logic       ms_tick_i,
  output logic [4:0] gain_l_o,
  output logic [4:0] gain_r_o,
  output logic [7:0] vol_l_o,
  output logic [7:0] vol_r_o
);
  localparam int CNT_W = $clog2(BASE_MS * 8 + 1);

  zc_mode_t         mode;
  gain_t            gain_in  [N_CH];
  vol_t             vol_in   [N_CH];
  gain_t            gain_out [N_CH];
  vol_t             vol_out  [N_CH];
  logic [N_CH-1:0]  zc_g, zc_v, pend_w, commit_w;
  logic             expire_w, any_pend_w;
  logic [CNT_W-1:0] tcnt_w, tlimit_w;

  assign mode = '{gate_en: gate_en_i, stage_sel: stage_sel_i,
                  auto_sel: auto_i, tmo_sel: tmo_sel_i};

  assign gain_in[0] = gain_l_i;
  assign gain_in[1] = gain_r_i;
  assign vol_in[0]  = vol_l_i;
  assign vol_in[1]  = vol_r_i;
  assign zc_g       = {zc_gain_r_i, zc_gain_l_i};
  assign zc_v       = {zc_vol_r_i, zc_vol_l_i};
  assign any_pend_w = |pend_w;

  zc_timeout #(.BASE_MS(BASE_MS), .CNT_W(CNT_W)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .tmo_sel_i (tmo_sel_i),
    .any_pend_i(any_pend_w),
    .ms_tick_i (ms_tick_i),
    .expire_o  (expire_w),
    .cnt_o     (tcnt_w),
    .limit_o   (tlimit_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    zc_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .mode_i   (mode),
      .gain_i   (gain_in[c]),
      .vol_i    (vol_in[c]),
      .zc_gain_i(zc_g[c]),
      .zc_vol_i (zc_v[c]),
      .expire_i (expire_w),
      .gain_o   (gain_out[c]),
      .vol_o    (vol_out[c]),
      .pend_o   (pend_w[c]),
      .commit_o (commit_w[c])
    );
  end

  assign gain_l_o = gain_out[0];
  assign gain_r_o = gain_out[1];
  assign vol_l_o  = vol_out[0];
  assign vol_r_o  = vol_out[1];
endmodule

// File: rtl/zc_gain_updater_chk.sv
module zc_gain_updater_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             gate_en_i,
  input logic [1:0]       pend_w,
  input logic [1:0]       commit_w,
  input logic             expire_w,
  input logic [CNT_W-1:0] tcnt_w,
  input logic [CNT_W-1:0] tlimit_w,
  input logic [4:0]       gain_l_o,
  input logic [4:0]       gain_r_o,
  input logic [7:0]       vol_l_o,
  input logic [7:0]       vol_r_o
);
  // R3: outputs move only on a load or a commit
  assert_hold_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !commit_w[0]) |=> ($stable(gain_l_o) && $stable(vol_l_o)));
  assert_hold_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !commit_w[1]) |=> ($stable(gain_r_o) && $stable(vol_r_o)));
  // R6: each channel commits only with its own pending change
  assert_commit_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_w & ~pend_w) == 2'b00));
  // R8: a gated load always leaves both channels pending
  assert_gated_load_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && gate_en_i) |=> (pend_w == 2'b11));
  // R11: an immediate load clears any pending change
  assert_direct_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !gate_en_i) |=> (pend_w == 2'b00));
  // R7: counter stays inside the selected window; expiry needs a pending change
  assert_cnt_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt_w < tlimit_w) || (pend_w == 2'b00));
  assert_expire_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |-> (pend_w != 2'b00));
  // R9 / R10: applied codes are always legal
  assert_vol_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((vol_l_o <= 8'd80) || (vol_l_o >= 8'd118 && vol_l_o <= 8'd127)) &&
    ((vol_r_o <= 8'd80) || (vol_r_o >= 8'd118 && vol_r_o <= 8'd127)));
  assert_gain_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l_o <= 5'd18) && (gain_r_o <= 5'd18));
endmodule

bind zc_gain_updater zc_gain_updater_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .gate_en_i(gate_en_i),
  .pend_w  (pend_w),
  .commit_w(commit_w),
  .expire_w(expire_w),
  .tcnt_w  (tcnt_w),
  .tlimit_w(tlimit_w),
  .gain_l_o(gain_l_o),
  .gain_r_o(gain_r_o),
  .vol_l_o (vol_l_o),
  .vol_r_o (vol_r_o)
);

// File: tb/zc_gain_updater_tb.sv
module zc_gain_updater_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 0, gate_en_i = 0, stage_sel_i = 0, auto_i = 0;
  logic [1:0] tmo_sel_i = 0;
  logic [4:0] gain_l_i = 0, gain_r_i = 0;
  logic [7:0] vol_l_i = 0, vol_r_i = 0;
  logic       zc_gain_l_i = 0, zc_gain_r_i = 0, zc_vol_l_i = 0, zc_vol_r_i = 0;
  logic       ms_tick_i = 0;
  logic [4:0] gain_l_o, gain_r_o;
  logic [7:0] vol_l_o, vol_r_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  zc_gain_updater u_dut (.*);

  function automatic int want_gain(input int g);
    if (g > 18) return 18;
    return g;
  endfunction

  function automatic int want_vol(input int v);
    if (v inside {[0:80], [118:127]}) return v;
    return 80;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check4(input string req, input int gl, input int gr,
                        input int vl, input int vr);
    check(req, gain_l_o, gl);
    check(req, gain_r_o, gr);
    check(req, vol_l_o, vl);
    check(req, vol_r_o, vr);
  endtask

  task automatic load(input logic en, input logic sel, input logic au,
                      input logic [1:0] tm, input int gl, input int gr,
                      input int vl, input int vr);
    @(negedge clk);
    load_i = 1; gate_en_i = en; stage_sel_i = sel; auto_i = au; tmo_sel_i = tm;
    gain_l_i = 5'(gl); gain_r_i = 5'(gr); vol_l_i = 8'(vl); vol_r_i = 8'(vr);
    @(negedge clk);
    load_i = 0;
  endtask

  // which: 0 gain-left, 1 gain-right, 2 vol-left, 3 vol-right
  task automatic pulse(input int which);
    @(negedge clk);
    zc_gain_l_i = (which == 0); zc_gain_r_i = (which == 1);
    zc_vol_l_i  = (which == 2); zc_vol_r_i  = (which == 3);
    @(negedge clk);
    {zc_gain_l_i, zc_gain_r_i, zc_vol_l_i, zc_vol_r_i} = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick_i = 1;
    end
    @(negedge clk); ms_tick_i = 0;
  endtask

  task automatic t_reset;
    check4("R1", 0, 0, 80, 80);
  endtask

  task automatic t_direct;
    load(0, 0, 0, 0, 5, 25, 118, 100);
    check4("R2 R9 R10", 5, want_gain(25), 118, want_vol(100));
    load(0, 0, 0, 0, 18, 0, 79, 127);
    check4("R2 R9", 18, 0, 79, 127);
  endtask

  task automatic t_manual_gain;
    load(1, 0, 0, 3, 3, 4, 20, 21);
    check4("R3", 18, 0, 79, 127);
    pulse(2);
    check4("R3 R4", 18, 0, 79, 127);
    pulse(0);
    check4("R4 R6", 3, 0, 20, 127);
    pulse(1);
    check4("R6", 3, 4, 20, 21);
  endtask

  task automatic t_manual_vol;
    load(1, 1, 0, 3, 7, 8, 30, 31);
    pulse(0); pulse(1);
    check4("R4", 3, 4, 20, 21);
    pulse(3);
    check4("R4 R6", 3, 8, 20, 31);
    pulse(2);
    check4("R4", 7, 8, 30, 31);
  endtask

  task automatic t_auto;
    // left volume changes, right volume stays: stage_sel ignored
    load(1, 1, 1, 3, 9, 10, 40, 31);
    pulse(0);
    check4("R5", 7, 8, 30, 31);
    pulse(3);
    check4("R5", 7, 8, 30, 31);
    pulse(2);
    check4("R5", 9, 8, 40, 31);
    pulse(1);
    check4("R5", 9, 10, 40, 31);
  endtask

  task automatic t_timeout(input logic [1:0] tm, input int ms);
    load(1, 0, 0, tm, 11, 12, 50, 51);
    ticks(ms - 1);
    check4("R7 before", 9, 10, 40, 31);
    ticks(1);
    check4("R7 at limit", 11, 12, 50, 51);
    load(0, 0, 0, 0, 9, 10, 40, 31);
  endtask

  task automatic t_replace;
    load(1, 0, 0, 0, 1, 2, 60, 61);
    ticks(5);
    load(1, 0, 0, 0, 13, 14, 62, 63);
    ticks(9);
    check4("R8 restart", 9, 10, 40, 31);
    ticks(1);
    check4("R8 replaced", 13, 14, 62, 63);
  endtask

  task automatic t_switch;
    load(1, 0, 0, 0, 2, 2, 2, 2);
    load(0, 0, 0, 0, 15, 16, 70, 200);
    check4("R11", 15, 16, 70, 80);
    pulse(0); pulse(1); pulse(2); pulse(3);
    ticks(25);
    check4("R11 R12", 15, 16, 70, 80);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_manual_gain();
    t_manual_vol();
    t_auto();
    t_timeout(2'd0, 10);
    t_timeout(2'd1, 20);
    t_timeout(2'd2, 40);
    t_timeout(2'd3, 80);
    t_replace();
    t_switch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule